// File: doc/BRIEF.md
# Bit Manipulation and Status Unit

This unit carries out five operations for a small processor core. Three act on one bit of a byte. Bit set and bit clear perform a read-modify-write of a single memory byte. Bit test copies one bit of the source operand into a condition flag. The other two operations load or mask the low byte of control register 0, which is the status word. The decoder presents an operation code with a strobe. The operands are a 3-bit bit index, an 8-bit immediate, a 32-bit source value and a 16-bit displacement that is sign-extended.

Bits inside a byte are numbered from the most significant end, so index 0 names bit 7 and index 7 names bit 0. Memory accesses go over a byte-wide port. The unit raises a request and holds it until read data is flagged valid, then issues one write cycle. Each completed operation ends with a one-cycle done pulse, which comes with the amount to add to the program counter.

Top module: `bitstat_unit`

## Requirements
- R1: An operation is launched when `start` is high and the unit is idle. The `op` encodings are 1 = bit set, 2 = bit clear, 3 = bit test, 4 = status clear and 5 = status set. Codes 0, 6 and 7 produce no done pulse, no memory request and no register change.
- R2: The byte address is `src_val` plus `disp` sign-extended to 32 bits, added modulo 2^32. `mem_addr` holds this value for the whole access.
- R3: Bit set reads the addressed byte and writes back the byte ORed with 0x80 shifted right by `bit_idx`.
- R4: Bit clear reads the addressed byte and writes back the byte ANDed with the inverse of that same mask.
- R5: Bit test sets `cond_flag` to bit (7 - `bit_idx`) of `src_val`. It makes no memory request.
- R6: Status clear keeps bits 15:8 of `ctl_reg0`, clears bits 31:16, and clears each bit of 7:0 for which the immediate holds a 1.
- R7: Status set loads `ctl_reg0` with the immediate zero-extended to 32 bits.
- R8: When `done` is high, `pc_inc` is 4 for bit set and bit clear and 2 for the other three operations. Otherwise it is 0.
- R9: A memory operation keeps `mem_req` high with `mem_we` low until `mem_rvalid` arrives. It then drives exactly one write cycle to the same address, and `done` rises for one cycle on the next clock. A register-only operation gives its done pulse on the clock after it is accepted. Exactly one byte is written per bit set or bit clear.
- R10: Synchronous active-high `rst` clears `ctl_reg0` and `cond_flag`, drops `done` and `mem_req`, and returns the unit to idle.
- R11: A `start` presented while a memory operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Operation strobe |
| op | input | 3 | Operation code |
| bit_idx | input | 3 | Bit index, 0 = most significant bit |
| imm | input | 8 | Immediate for the status operations |
| src_val | input | 32 | Source register value |
| disp | input | 16 | Signed displacement |
| mem_req | output | 1 | Memory request |
| mem_addr | output | 32 | Byte address |
| mem_we | output | 1 | Write enable, qualified by mem_req |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte |
| mem_rvalid | input | 1 | Read data valid |
| ctl_reg0 | output | 32 | Control register 0 (status word) |
| cond_flag | output | 1 | Condition flag |
| done | output | 1 | Completion pulse |
| pc_inc | output | 3 | Program counter increment |

## Verification
The assertions check several rules on every cycle:
- A write always comes with a request and lasts a single cycle.
- The address does not move while a request is held.
- The sequencer goes back to idle after done.
- The two sources of done never coincide.
- The status-set and status-clear results hold in the cycle after each such operation.
- The flag stays fixed when no test runs.

Other behaviour can only be shown by the bench's scenarios, which compare against a byte-array memory:
- the MSB-first bit numbering over all eight indices;
- the effect on the data byte and its neighbours;
- address wrap with negative displacements;
- the discarding of undefined codes and of strobes that arrive while busy.

// File: rtl/bitstat_pkg.sv
package bitstat_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_BSET = 3'd1,
        OP_BCLR = 3'd2,
        OP_BTST = 3'd3,
        OP_SCLR = 3'd4,
        OP_SSET = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_DONE
    } rmw_st_e;

    typedef struct packed {
        logic             is_clr;
        logic [IDX_W-1:0] idx;
    } bit_cmd_t;

    localparam logic [2:0] INC_LONG  = 3'd4;
    localparam logic [2:0] INC_SHORT = 3'd2;

    // MSB-first mask: index 0 selects the top bit of the byte
    function automatic logic [BYTE_W-1:0] msb_mask(input logic [IDX_W-1:0] idx);
        return {1'b1, {(BYTE_W-1){1'b0}}} >> idx;
    endfunction

endpackage

// File: rtl/bitstat_bitops.sv
module bitstat_bitops
    import bitstat_pkg::*;
(
    input  bit_cmd_t          cmd,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [BYTE_W-1:0] probe_in,
    output logic [BYTE_W-1:0] byte_out,
    output logic              probe_bit
);
    logic [BYTE_W-1:0] mask;

    always_comb begin
        mask      = msb_mask(cmd.idx);
        byte_out  = cmd.is_clr ? (byte_in & ~mask) : (byte_in | mask);
        probe_bit = |(probe_in & mask);
    end
endmodule

// File: rtl/bitstat_rmw_seq.sv
module bitstat_rmw_seq
    import bitstat_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  bit_cmd_t          cmd_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_rvalid,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              idle,
    output logic              fin
);
    rmw_st_e           st_q;
    bit_cmd_t          cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] wbyte_q;
    logic [BYTE_W-1:0] mod_byte;
    logic              unused_probe;

    bitstat_bitops u_ops (
        .cmd       (cmd_q),
        .byte_in   (mem_rdata),
        .probe_in  ({BYTE_W{1'b0}}),
        .byte_out  (mod_byte),
        .probe_bit (unused_probe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            cmd_q   <= '0;
            addr_q  <= '0;
            wbyte_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (launch) begin
                    cmd_q  <= cmd_in;
                    addr_q <= addr_in;
                    st_q   <= ST_READ;
                end
                ST_READ: if (mem_rvalid) begin
                    wbyte_q <= mod_byte;
                    st_q    <= ST_WRITE;
                end
                ST_WRITE: st_q <= ST_DONE;
                ST_DONE:  st_q <= ST_IDLE;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = (st_q == ST_READ) || (st_q == ST_WRITE);
        mem_we    = (st_q == ST_WRITE);
        mem_addr  = addr_q;
        mem_wdata = wbyte_q;
        idle      = (st_q == ST_IDLE);
        fin       = (st_q == ST_DONE);
    end

    AST_WE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst) mem_we |-> mem_req); // R9
    AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (rst) mem_we |=> !mem_we); // R9
    AST_FIN_TO_IDLE: assert property (@(posedge clk) disable iff (rst) fin |=> idle); // R9
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && $past(mem_req)) |-> $stable(mem_addr)); // R2
endmodule

// File: rtl/bitstat_ctl_regs.sv
module bitstat_ctl_regs
    import bitstat_pkg::*;
#(
    parameter int CR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclr_en,
    input  logic              sset_en,
    input  logic              tst_en,
    input  logic [BYTE_W-1:0] imm,
    input  logic              tst_bit,
    output logic [CR_W-1:0]   cr_q,
    output logic              cond_q
);
    localparam int KEEP_HI = 2 * BYTE_W;

    logic [CR_W-1:0] cr_nxt;

    for (genvar g = 0; g < CR_W; g++) begin : g_bit
        if (g < BYTE_W) begin : g_lo
            assign cr_nxt[g] = sset_en ? imm[g]
                             : sclr_en ? (cr_q[g] & ~imm[g])
                             : cr_q[g];
        end else if (g < KEEP_HI) begin : g_mid
            assign cr_nxt[g] = sset_en ? 1'b0 : cr_q[g];
        end else begin : g_hi
            assign cr_nxt[g] = (sset_en || sclr_en) ? 1'b0 : cr_q[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cr_q   <= '0;
            cond_q <= 1'b0;
        end else begin
            cr_q <= cr_nxt;
            if (tst_en) cond_q <= tst_bit;
        end
    end

    AST_SSET_LOADS: assert property (@(posedge clk) disable iff (rst)
        sset_en |=> (cr_q == CR_W'($past(imm)))); // R7
    AST_SCLR_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        sclr_en |=> (cr_q[CR_W-1:KEEP_HI] == '0)); // R6
    AST_SCLR_MID_KEPT: assert property (@(posedge clk) disable iff (rst)
        sclr_en |=> (cr_q[KEEP_HI-1:BYTE_W] == $past(cr_q[KEEP_HI-1:BYTE_W]))); // R6
    AST_COND_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !tst_en |=> $stable(cond_q)); // R5
endmodule

// File: rtl/bitstat_unit.sv
module bitstat_unit
    import bitstat_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16,
    parameter int CR_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic [BYTE_W-1:0] imm,
    input  logic [ADDR_W-1:0] src_val,
    input  logic [DISP_W-1:0] disp,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_rvalid,
    output logic [CR_W-1:0]   ctl_reg0,
    output logic              cond_flag,
    output logic              done,
    output logic [2:0]        pc_inc
);
    localparam int EXT_W = ADDR_W - DISP_W;

    op_e               op_c;
    logic              idle, rmw_fin, accept;
    logic              go_mem, go_tst, go_sclr, go_sset;
    logic              reg_done_q;
    logic [ADDR_W-1:0] eff_addr;
    bit_cmd_t          cmd;
    logic              tst_bit;
    logic [BYTE_W-1:0] unused_byte;

    always_comb begin
        op_c     = op_e'(op);
        accept   = start && idle;
        go_mem   = accept && (op_c == OP_BSET || op_c == OP_BCLR);
        go_tst   = accept && (op_c == OP_BTST);
        go_sclr  = accept && (op_c == OP_SCLR);
        go_sset  = accept && (op_c == OP_SSET);
        eff_addr = src_val + {{EXT_W{disp[DISP_W-1]}}, disp};
        cmd      = '{is_clr: (op_c == OP_BCLR), idx: bit_idx};
    end

    bitstat_bitops u_probe (
        .cmd       (cmd),
        .byte_in   ({BYTE_W{1'b0}}),
        .probe_in  (src_val[BYTE_W-1:0]),
        .byte_out  (unused_byte),
        .probe_bit (tst_bit)
    );

    bitstat_rmw_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .launch     (go_mem),
        .cmd_in     (cmd),
        .addr_in    (eff_addr),
        .mem_rdata  (mem_rdata),
        .mem_rvalid (mem_rvalid),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .idle       (idle),
        .fin        (rmw_fin)
    );

    bitstat_ctl_regs #(.CR_W(CR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .sclr_en (go_sclr),
        .sset_en (go_sset),
        .tst_en  (go_tst),
        .imm     (imm),
        .tst_bit (tst_bit),
        .cr_q    (ctl_reg0),
        .cond_q  (cond_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) reg_done_q <= 1'b0;
        else     reg_done_q <= go_tst || go_sclr || go_sset;
    end

    always_comb begin
        done   = rmw_fin || reg_done_q;
        pc_inc = rmw_fin ? INC_LONG : (reg_done_q ? INC_SHORT : 3'd0);
    end

    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rmw_fin && reg_done_q)); // R9
    AST_PC_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> (pc_inc == INC_LONG || pc_inc == INC_SHORT)); // R8
    AST_NO_REQ_IDLE_TEST: assert property (@(posedge clk) disable iff (rst)
        (go_tst && idle) |=> !mem_req); // R5
endmodule

// File: tb/bitstat_unit_tb_top.sv
module bitstat_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [2:0]  bit_idx = '0;
    logic [7:0]  imm = '0;
    logic [31:0] src_val = '0;
    logic [15:0] disp = '0;
    logic        mem_req, mem_we, cond_flag, done;
    logic [31:0] mem_addr, ctl_reg0;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mem_rvalid = 1'b0;
    logic [2:0]  pc_inc;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitstat_unit dut_i (
        .clk(clk), .rst(rst), .start(start), .op(op), .bit_idx(bit_idx),
        .imm(imm), .src_val(src_val), .disp(disp),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .ctl_reg0(ctl_reg0), .cond_flag(cond_flag), .done(done), .pc_inc(pc_inc)
    );

    // byte memory model, 256 bytes indexed by the low address byte
    logic [7:0]  mem [256];
    logic        pl_en = 1'b0;
    logic [7:0]  pl_addr = '0, pl_data = '0;
    int          wr_cnt = 0;
    logic [31:0] last_waddr = '0;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'hA5;
            mem_rvalid <= 1'b0;
        end else begin
            mem_rvalid <= mem_req && !mem_we && !mem_rvalid;
            mem_rdata  <= mem[mem_addr[7:0]];
            if (mem_req && mem_we) begin
                mem[mem_addr[7:0]] <= mem_wdata;
                wr_cnt     <= wr_cnt + 1;
                last_waddr <= mem_addr;
            end
            if (pl_en) mem[pl_addr] <= pl_data;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_checks = n_checks + 1;
            n_fail   = n_fail + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic preload(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); pl_en = 1'b1; pl_addr = a; pl_data = d;
        @(negedge clk); pl_en = 1'b0;
    endtask

    // issue one operation, wait for done; returns whether done was seen and pc_inc
    task automatic run_op(input logic [2:0] o, input logic [2:0] ix, input logic [7:0] im,
                          input logic [31:0] s, input logic [15:0] d,
                          output logic seen, output logic [2:0] pc);
        @(negedge clk);
        start = 1'b1; op = o; bit_idx = ix; imm = im; src_val = s; disp = d;
        @(negedge clk);
        start = 1'b0;
        seen = 1'b0; pc = '0;
        for (int k = 0; k < 12 && !seen; k++) begin
            if (done) begin seen = 1'b1; pc = pc_inc; end
            else @(negedge clk);
        end
    endtask

    // {initial byte, source low byte, displacement low byte}; displacement is {8'hFF, low}
    localparam logic [23:0] VEC [8] = '{
        24'h00_80_10, 24'hFF_40_28, 24'h5A_00_3C, 24'hA5_FF_50,
        24'h0F_10_6E, 24'hF0_EF_90, 24'h3C_02_B4, 24'hC3_01_D8
    };
    localparam logic [31:0] BASE = 32'h2000_0100;

    initial begin
        logic        seen;
        logic [2:0]  pc;
        logic [7:0]  init_b, src_b, d_lo, msk, after_set, nb_lo, nb_hi;
        logic [31:0] ea;
        int          wc0;

        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 ctl_reg0 after reset", ctl_reg0, 32'h0);
        check("R10 cond_flag after reset", {31'b0, cond_flag}, 32'h0);
        check("R10 done after reset", {31'b0, done}, 32'h0);
        check("R10 mem_req after reset", {31'b0, mem_req}, 32'h0);
        @(negedge clk); rst = 1'b0;

        for (int i = 0; i < 8; i++) begin
            init_b = VEC[i][23:16]; src_b = VEC[i][15:8]; d_lo = VEC[i][7:0];
            msk = 8'h80 >> i;
            ea  = BASE + {{16{1'b1}}, 8'hFF, d_lo};
            nb_lo = mem[ea[7:0] - 8'd1]; nb_hi = mem[ea[7:0] + 8'd1];
            preload(ea[7:0], init_b);
            wc0 = wr_cnt;
            run_op(3'd1, 3'(i), 8'h00, BASE, {8'hFF, d_lo}, seen, pc);
            after_set = init_b | msk;
            check("R3 bit set result", {24'b0, mem[ea[7:0]]}, {24'b0, after_set});
            check("R2 write address", last_waddr, ea);
            check("R9 one write per op", wr_cnt - wc0, 1);
            check("R8 pc_inc bit set", {29'b0, pc}, 32'd4);
            @(negedge clk);
            check("R9 done one cycle", {31'b0, done}, 32'h0);
            wc0 = wr_cnt;
            run_op(3'd2, 3'(i), 8'h00, BASE, {8'hFF, d_lo}, seen, pc);
            check("R4 bit clear result", {24'b0, mem[ea[7:0]]}, {24'b0, after_set & ~msk});
            check("R8 pc_inc bit clear", {29'b0, pc}, 32'd4);
            check("R9 neighbour below untouched", {24'b0, mem[ea[7:0] - 8'd1]}, {24'b0, nb_lo});
            check("R9 neighbour above untouched", {24'b0, mem[ea[7:0] + 8'd1]}, {24'b0, nb_hi});
            wc0 = wr_cnt;
            run_op(3'd3, 3'(i), 8'h00, {24'hFFFF00, src_b}, 16'h0, seen, pc);
            check("R5 bit test flag", {31'b0, cond_flag}, {31'b0, src_b[7-i]});
            check("R5 test no write", wr_cnt - wc0, 0);
            check("R8 pc_inc bit test", {29'b0, pc}, 32'd2);
        end

        // R2 wrap-around address with a positive displacement
        run_op(3'd1, 3'd7, 8'h00, 32'hFFFF_FFF8, 16'h0010, seen, pc);
        check("R2 wrapped address", last_waddr, 32'h0000_0008);

        // R7 / R6 status operations
        run_op(3'd5, 3'd0, 8'hFF, 32'h0, 16'h0, seen, pc);
        check("R7 status set", ctl_reg0, 32'h0000_00FF);
        check("R8 pc_inc status set", {29'b0, pc}, 32'd2);
        run_op(3'd4, 3'd0, 8'h5A, 32'h0, 16'h0, seen, pc);
        check("R6 status clear", ctl_reg0, 32'h0000_00A5);
        check("R8 pc_inc status clear", {29'b0, pc}, 32'd2);
        run_op(3'd5, 3'd0, 8'h3C, 32'h0, 16'h0, seen, pc);
        check("R7 status set overwrite", ctl_reg0, 32'h0000_003C);
        run_op(3'd4, 3'd0, 8'h00, 32'h0, 16'h0, seen, pc);
        check("R6 status clear zero imm keeps", ctl_reg0, 32'h0000_003C);

        // R1 undefined codes ignored
        for (int c = 0; c < 3; c++) begin
            logic [2:0] code;
            code = (c == 0) ? 3'd0 : ((c == 1) ? 3'd6 : 3'd7);
            wc0 = wr_cnt;
            run_op(code, 3'd0, 8'h11, 32'h0, 16'h0, seen, pc);
            check("R1 undefined code no done", {31'b0, seen}, 32'h0);
            check("R1 undefined code no reg change", ctl_reg0, 32'h0000_003C);
            check("R1 undefined code no write", wr_cnt - wc0, 0);
        end

        // R11 start while busy ignored
        @(negedge clk);
        start = 1'b1; op = 3'd1; bit_idx = 3'd0; src_val = BASE; disp = 16'hFF20;
        @(negedge clk);
        op = 3'd5; imm = 8'h77;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        check("R11 busy start ignored", ctl_reg0, 32'h0000_003C);

        // R10 reset clears flag and register
        run_op(3'd3, 3'd7, 8'h00, 32'h1, 16'h0, seen, pc);
        check("R5 flag set before reset", {31'b0, cond_flag}, 32'h1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10 flag cleared", {31'b0, cond_flag}, 32'h0);
        check("R10 register cleared", ctl_reg0, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule